// File: doc/BRIEF.md
# Edge-Latched Interrupt Aggregator

This block gathers a set of single-bit interrupt requests from neighbouring blocks, such as an over-temperature warning, an acquisition trigger, an end-of-acquisition event or a finished serial-bus transfer. The block turns every rising edge on a request line into a sticky bit in a pending register. A read of the pending register returns its contents and clears them. A second register holds one enable bit per line. When a line with its enable bit set shows a rising edge, the block sends the host bridge a single positive pulse one clock wide.

Software reaches both registers through a small request/acknowledge register port. The pending register is at word address 0 and is read-only. A read of it clears the bits it returns. The enable register is at word address 1 and can be read and written. The clear never discards an edge that arrives in the same cycle as the read. Such an edge stays pending and appears in the following read.

Top module: `irqagg_top`

## Requirements
- R1: A rising edge on request input bit i sets bit i of the pending register (word address 0). Setting it does not disturb the other bits.
- R2: Only edges are recorded. A line held high sets its bit once and does not set it again after a clear. Each line's previous value is taken as 0 at reset, so a line that is already high when reset is released records one event.
- R3: A read of address 0 returns the pending register's value from before the read, then clears every returned bit.
- R4: A rising edge in the same cycle as a pending-register read is absent from that read's data. It is present in the next read.
- R5: The enable register (word address 1, bit i gates line i) resets to all zeros. It takes the low NUM_SRC bits of written data and reads back what was written, zero-extended.
- R6: Writes to address 0 leave the pending register unchanged. Reads of addresses 2 and 3 return zero.
- R7: An edge on a line whose enable bit is 1 drives irqOut high for exactly the one cycle after the edge cycle. An edge on a disabled line causes no pulse but is still latched.
- R8: Several enabled edges in the same cycle produce one single-cycle pulse.
- R9: After reset, irqOut and busAck are low and both registers read zero, apart from the events described in R2.
- R10: Every request on the register port is acknowledged by busAck high in the following cycle. Read data is valid with that acknowledge, and busAck is low when there was no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | NUM_SRC | Interrupt request lines, one per source |
| busReq | input | 1 | Register access request, one cycle per access |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Word address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, valid with busAck |
| busAck | output | 1 | Access acknowledge, one cycle after busReq |
| irqOut | output | 1 | One-cycle interrupt pulse toward the host |

## Verification
The patterns tried are:
- a single pulse on an enabled line;
- a single pulse on a disabled line;
- two enabled lines pulsing in the same cycle;
- a line held high across a clear;
- a line already high when reset is released;
- a read issued in the same cycle as a new edge.

The single enabled and disabled pulses separate gating from latching. The simultaneous pulses show that events are merged into one pulse. The held line separates edge detection from level detection. The coincident read shows whether a clear can override a new edge. Writes to the read-only address and reads of unused addresses confirm that neither changes any state.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  localparam int unsigned SRC_WORD = 0;
  localparam int unsigned EN_WORD  = 1;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_SRC  = 2'd1,
    SEL_EN   = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic   srcRead;
    logic   enWrite;
    logic   rdStrobe;
    rdSel_e rdSel;
  } ctlStrobes_t;

endpackage

// File: rtl/irqagg_ctrl.sv
module irqagg_ctrl
  import irqagg_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output ctlStrobes_t       strb,
  output logic              busAck
);

  localparam logic [ADDR_W-1:0] SRC_A = ADDR_W'(SRC_WORD);
  localparam logic [ADDR_W-1:0] EN_A  = ADDR_W'(EN_WORD);

  always_comb begin
    strb          = '0;
    strb.rdSel    = SEL_NONE;
    strb.rdStrobe = busReq && !busWe;
    strb.srcRead  = busReq && !busWe && (busAddr == SRC_A);
    strb.enWrite  = busReq && busWe && (busAddr == EN_A);
    if (busAddr == SRC_A)     strb.rdSel = SEL_SRC;
    else if (busAddr == EN_A) strb.rdSel = SEL_EN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busAck <= 1'b0;
    else       busAck <= busReq;
  end

  // R10
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq |=> busAck);
  // R10
  no_spurious_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busReq |=> !busAck);

endmodule

// File: rtl/irqagg_dp.sv
module irqagg_dp
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  ctlStrobes_t        strb,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irqOut
);

  logic [NUM_SRC-1:0] prevIn;
  logic [NUM_SRC-1:0] edgeVec;
  logic [NUM_SRC-1:0] srcReg;
  logic [NUM_SRC-1:0] enReg;
  logic [DATA_W-1:0]  rdMux;

  generate
    if (DATA_W > NUM_SRC) begin : g_spare
      logic unusedWdata;
      assign unusedWdata = ^busWdata[DATA_W-1:NUM_SRC];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevIn <= '0;
    else       prevIn <= irqIn;
  end

  assign edgeVec = irqIn & ~prevIn;

  // Per-bit sticky source: a new edge wins over a clearing read.
  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)           srcReg[i] <= 1'b0;
        else if (edgeVec[i]) srcReg[i] <= 1'b1;
        else if (strb.srcRead) srcReg[i] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             enReg <= '0;
    else if (strb.enWrite) enReg <= busWdata[NUM_SRC-1:0];
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_SRC: rdMux = DATA_W'(srcReg);
      SEL_EN:  rdMux = DATA_W'(enReg);
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              busRdata <= '0;
    else if (strb.rdStrobe) busRdata <= rdMux;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |(edgeVec & enReg);
  end

  // R4
  edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.srcRead && (edgeVec != '0)) |=> ((srcReg & $past(edgeVec)) == $past(edgeVec)));
  // R3
  read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.srcRead && (edgeVec == '0)) |=> (srcReg == '0));
  // R1
  sticky_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.srcRead |=> ((srcReg & $past(srcReg)) == $past(srcReg)));
  // R5
  enable_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.enWrite |=> (enReg == $past(busWdata[NUM_SRC-1:0])));
  // R7
  pulse_needs_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (srcReg != '0));

endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic               busReq,
  input  logic               busWe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               busAck,
  output logic               irqOut
);

  ctlStrobes_t strb;

  irqagg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWe(busWe),
    .busAddr(busAddr), .strb(strb), .busAck(busAck)
  );

  irqagg_dp #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .strb(strb),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

endmodule

// File: tb/sim_irqagg_top.sv
`timescale 1ns/1ps
module sim_irqagg_top;

  localparam int NS = 8;
  localparam int DW = 32;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] irqIn = '0;
  logic          busReq = 1'b0;
  logic          busWe = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic          busAck;
  logic          irqOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  // bit DW = compare flag, low bits = expected data
  logic [DW:0] expQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  irqagg_top #(.NUM_SRC(NS), .DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busReq(busReq), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busAck(busAck), .irqOut(irqOut)
  );

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per acknowledge.
  always @(negedge clk) begin
    if (rstN && busAck) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10 unexpected ack", 1, 0);
      end else begin
        logic [DW:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (e[DW]) check(busRdata == e[DW-1:0], t, busRdata, e[DW-1:0]);
      end
    end
  end

  task automatic busAccess(input bit we, input int addr, input logic [DW-1:0] wd,
                           input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    busReq = 1'b1; busWe = we; busAddr = AW'(addr); busWdata = wd;
    expQ.push_back({~we, exp});
    tagQ.push_back(tag);
    @(negedge clk);
    busReq = 1'b0; busWe = 1'b0;
    @(negedge clk);
    check(busAck == 1'b0, "R10 ack one cycle", busAck, 0);
  endtask

  task automatic pulseIn(input logic [NS-1:0] mask, input bit expPulse, input string tag);
    @(negedge clk);
    irqIn = mask;
    @(negedge clk);
    irqIn = '0;
    check(irqOut == expPulse, tag, irqOut, expPulse);
    @(negedge clk);
    check(irqOut == 1'b0, {tag, " width"}, irqOut, 0);
  endtask

  initial begin
    irqIn = 8'h80;               // R2: high before reset release
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check(irqOut == 1'b0 && busAck == 1'b0, "R9 reset outputs", {irqOut, busAck}, 0);
    busAccess(0, 1, 0, 32'h0, "R9 enable reset");
    busAccess(0, 0, 0, 32'h80, "R2 high at reset");
    busAccess(0, 0, 0, 32'h0, "R2 held level no retrigger");
    irqIn = '0;

    busAccess(1, 1, 32'hFFFF_FF05, 0, "R5 write");
    busAccess(0, 1, 0, 32'h05, "R5 readback");

    pulseIn(8'h01, 1'b1, "R7 enabled pulse");
    busAccess(0, 0, 0, 32'h01, "R1 bit0 latched");
    busAccess(0, 0, 0, 32'h00, "R3 cleared");

    pulseIn(8'h02, 1'b0, "R7 disabled no pulse");
    busAccess(0, 0, 0, 32'h02, "R7 disabled still latched");

    pulseIn(8'h05, 1'b1, "R8 merged pulse");
    busAccess(0, 0, 0, 32'h05, "R8 both latched");

    pulseIn(8'h08, 1'b0, "R1 bit3");
    busAccess(1, 0, 32'hFF, 0, "R6 write src");
    busAccess(0, 0, 0, 32'h08, "R6 src unchanged");
    busAccess(0, 2, 0, 32'h0, "R6 addr2");
    busAccess(0, 3, 0, 32'h0, "R6 addr3");

    pulseIn(8'h10, 1'b0, "R1 bit4");
    @(negedge clk);
    busReq = 1'b1; busWe = 1'b0; busAddr = 0;
    irqIn = 8'h20;
    expQ.push_back({1'b1, 32'h10});
    tagQ.push_back("R4 read excludes new edge");
    @(negedge clk);
    busReq = 1'b0; irqIn = '0;
    busAccess(0, 0, 0, 32'h20, "R4 edge survives clear");

    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "R10 all acks seen", expQ.size(), 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule